// File: doc/BRIEF.md
# BPSK Subcarrier Mapper with Null Insertion

This block turns one 56-bit payload frame into the 64 real frequency-domain samples that a 64-point inverse transform expects. Each payload bit becomes a fixed signed 16-bit BPSK level. Eight carriers stay empty: the DC carrier, and a run of seven in the middle of the frame that pads the 56 data carriers up to 64. The imaginary parts are zero and are not carried. The block does not perform the transform, add a cyclic prefix, filter, or drive any converter.

Payload enters on a valid/ready handshake. A build parameter selects one of two input forms. In the parallel form one beat carries the whole 56-bit frame. In the serial form 56 beats carry one bit each, and bit 0 arrives first. The samples leave as a valid/ready stream in carrier order. A start marker flags carrier 0 and an end marker flags carrier 63. One frame is held at a time, so the next frame is accepted only after the last sample of the current one has left.

Top module: `bpsk_null_mapper`

## Requirements
- R1: After a synchronous reset, `out_valid` is low and `in_ready` is high.
- R2: A payload bit of 0 produces the sample 0xBFFD and a payload bit of 1 produces 0x3FFF.
- R3: Sample index 0 (DC) is always 0x0000, and `out_sof` is high on that sample and on no other.
- R4: Sample indices 29 to 35 are always 0x0000.
- R5: Indices 1 to 28 carry payload bits 0 to 27 in order. Indices 36 to 63 carry payload bits 28 to 55 in order. Bit n of the parallel input word is payload bit n.
- R6: Each accepted frame yields exactly 64 accepted output samples. `out_eof` is high on index 63 only.
- R7: `in_ready` is low from the acceptance of a frame until the cycle after its last sample is accepted. Input offered in that window is ignored.
- R8: While `out_ready` is low, the current sample and its markers hold steady. No sample is dropped or repeated.
- R9: In serial mode, 56 accepted beats on `in_data[0]` form one frame, with the first beat as payload bit 0.
- R10: A reset during emission discards the rest of the frame. The next frame starts again at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | IN_W (56 parallel, 1 serial) | Payload word, or one payload bit in bit 0 |
| out_valid | output | 1 | Sample present |
| out_ready | input | 1 | Sink takes the sample |
| out_data | output | SW (16) | Real part of the current carrier sample |
| out_sof | output | 1 | Sample is carrier 0 |
| out_eof | output | 1 | Sample is carrier 63 |

## Verification
The assertions assume that the sink may hold `out_ready` low for any number of cycles. They also assume that the source may offer input at any time, including while a frame is being emitted, and they expect the block itself to refuse such input. The stimulus keeps the input side legal: each beat is held until it is accepted, and reset is applied only at clean cycle boundaries. Within that envelope the stimulus draws random back-pressure and random payloads. Directed cases cover all-zero and all-one frames, input offered while busy, and a reset in the middle of a frame.

// File: rtl/bpsk_map_pkg.sv
package bpsk_map_pkg;

   typedef enum logic {
      IN_PARALLEL = 1'b0,
      IN_SERIAL   = 1'b1
   } in_mode_e;

endpackage

// File: rtl/bpsk_frame_loader.sv
module bpsk_frame_loader
   import bpsk_map_pkg::*;
#(
   parameter int       BITS    = 56,
   parameter in_mode_e IN_MODE = IN_PARALLEL,
   parameter int       IN_W    = (IN_MODE == IN_PARALLEL) ? BITS : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [IN_W-1:0] in_data,
   input  logic            release_i,
   output logic            full_o,
   output logic [BITS-1:0] frame_o
);

   logic            full_q;
   logic [BITS-1:0] frame_q;

   assign full_o  = full_q;
   assign frame_o = frame_q;

   generate
      if (IN_MODE == IN_PARALLEL) begin : g_par
         always_ff @(posedge clk) begin
            if (rst) begin
               full_q  <= 1'b0;
               frame_q <= '0;
            end else if (release_i) begin
               full_q <= 1'b0;
            end else if (in_valid && !full_q) begin
               frame_q <= in_data;
               full_q  <= 1'b1;
            end
         end
      end else begin : g_ser
         localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
         logic [CW-1:0] pos_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               full_q  <= 1'b0;
               frame_q <= '0;
               pos_q   <= '0;
            end else if (release_i) begin
               full_q <= 1'b0;
            end else if (in_valid && !full_q) begin
               frame_q[pos_q] <= in_data[0];
               if (pos_q == CW'(BITS - 1)) begin
                  pos_q  <= '0;
                  full_q <= 1'b1;
               end else begin
                  pos_q <= pos_q + 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bpsk_index_seq.sv
module bpsk_index_seq #(
   parameter int SAMPLES = 64,
   parameter int IW      = $clog2(SAMPLES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          active_i,
   input  logic          advance_i,
   output logic [IW-1:0] idx_o,
   output logic          last_o,
   output logic          done_o
);

   logic [IW-1:0] idx_q;
   logic          step;

   assign step   = active_i && advance_i;
   assign last_o = (idx_q == IW'(SAMPLES - 1));
   assign done_o = step && last_o;
   assign idx_o  = idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
      end else if (step) begin
         idx_q <= last_o ? '0 : idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/bpsk_sample_sel.sv
module bpsk_sample_sel #(
   parameter int          BITS         = 56,
   parameter int          SAMPLES      = 64,
   parameter int          SW           = 16,
   parameter int          LOW_CARRIERS = 28,
   parameter int          MID_NULLS    = 7,
   parameter logic [SW-1:0] ZERO_WORD  = 16'hBFFD,
   parameter logic [SW-1:0] ONE_WORD   = 16'h3FFF,
   parameter int          IW           = $clog2(SAMPLES)
) (
   input  logic [BITS-1:0] frame_i,
   input  logic [IW-1:0]   idx_i,
   output logic [SW-1:0]   sample_o
);

   localparam int MID_FIRST = LOW_CARRIERS + 1;
   localparam int MID_LAST  = LOW_CARRIERS + MID_NULLS;

   logic [SW-1:0] lut [SAMPLES];

   generate
      for (genvar k = 0; k < SAMPLES; k++) begin : g_car
         if (k == 0 || (k >= MID_FIRST && k <= MID_LAST)) begin : g_null
            assign lut[k] = '0;
         end else if (k < MID_FIRST) begin : g_low
            assign lut[k] = frame_i[k-1] ? ONE_WORD : ZERO_WORD;
         end else begin : g_high
            assign lut[k] = frame_i[k-1-MID_NULLS] ? ONE_WORD : ZERO_WORD;
         end
      end
   endgenerate

   assign sample_o = lut[idx_i];

endmodule

// File: rtl/bpsk_null_mapper.sv
module bpsk_null_mapper
   import bpsk_map_pkg::*;
#(
   parameter int            BITS         = 56,
   parameter int            SAMPLES      = 64,
   parameter int            SW           = 16,
   parameter int            LOW_CARRIERS = 28,
   parameter int            MID_NULLS    = 7,
   parameter logic [SW-1:0] ZERO_WORD    = 16'hBFFD,
   parameter logic [SW-1:0] ONE_WORD     = 16'h3FFF,
   parameter in_mode_e      IN_MODE      = IN_PARALLEL,
   parameter int            IN_W         = (IN_MODE == IN_PARALLEL) ? BITS : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [IN_W-1:0] in_data,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [SW-1:0]   out_data,
   output logic            out_sof,
   output logic            out_eof
);

   localparam int IW = $clog2(SAMPLES);

   generate
      if (BITS + 1 + MID_NULLS != SAMPLES) begin : g_bad_count
         $error("data carriers plus nulls must equal SAMPLES");
      end
      if (LOW_CARRIERS < 1 || LOW_CARRIERS > BITS) begin : g_bad_split
         $error("LOW_CARRIERS out of range");
      end
      if (IN_W != ((IN_MODE == IN_PARALLEL) ? BITS : 1)) begin : g_bad_inw
         $error("IN_W does not match IN_MODE");
      end
   endgenerate

   logic            full;
   logic            done;
   logic            last;
   logic [IW-1:0]   idx;
   logic [BITS-1:0] frame;

   bpsk_frame_loader #(
      .BITS    (BITS),
      .IN_MODE (IN_MODE),
      .IN_W    (IN_W)
   ) u_load (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .release_i (done),
      .full_o    (full),
      .frame_o   (frame)
   );

   bpsk_index_seq #(
      .SAMPLES (SAMPLES),
      .IW      (IW)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .active_i  (full),
      .advance_i (out_ready),
      .idx_o     (idx),
      .last_o    (last),
      .done_o    (done)
   );

   bpsk_sample_sel #(
      .BITS         (BITS),
      .SAMPLES      (SAMPLES),
      .SW           (SW),
      .LOW_CARRIERS (LOW_CARRIERS),
      .MID_NULLS    (MID_NULLS),
      .ZERO_WORD    (ZERO_WORD),
      .ONE_WORD     (ONE_WORD),
      .IW           (IW)
   ) u_sel (
      .frame_i  (frame),
      .idx_i    (idx),
      .sample_o (out_data)
   );

   assign in_ready  = !full;
   assign out_valid = full;
   assign out_sof   = full && (idx == '0);
   assign out_eof   = full && last;

endmodule

// File: rtl/bpsk_null_mapper_chk.sv
module bpsk_null_mapper_chk #(
   parameter int            SAMPLES   = 64,
   parameter int            SW        = 16,
   parameter logic [SW-1:0] ZERO_WORD = 16'hBFFD,
   parameter logic [SW-1:0] ONE_WORD  = 16'h3FFF
) (
   input logic          clk,
   input logic          rst,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [SW-1:0] out_data,
   input logic          out_sof,
   input logic          out_eof
);

   localparam int CW = $clog2(SAMPLES) + 1;
   logic [CW-1:0] beats;

   always_ff @(posedge clk) begin
      if (rst) begin
         beats <= '0;
      end else if (out_valid && out_ready) begin
         beats <= out_eof ? '0 : beats + 1'b1;
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && in_ready));

   // R2
   legal_word_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data == '0 || out_data == ZERO_WORD || out_data == ONE_WORD));

   // R3
   dc_null_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_sof) |-> (out_data == '0 && beats == '0));

   // R6
   frame_len_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_eof) |-> (beats == CW'(SAMPLES - 1) && !out_sof));

   // R7
   busy_block_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !in_ready);

   // R7
   reopen_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_eof) |=> (!out_valid && in_ready));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_sof) && $stable(out_eof)));

endmodule

bind bpsk_null_mapper bpsk_null_mapper_chk #(
   .SAMPLES   (SAMPLES),
   .SW        (SW),
   .ZERO_WORD (ZERO_WORD),
   .ONE_WORD  (ONE_WORD)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_sof   (out_sof),
   .out_eof   (out_eof)
);

// File: tb/bpsk_null_mapper_test.sv
`timescale 1ns/1ps
module bpsk_null_mapper_test;
   import bpsk_map_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        p_valid = 1'b0, s_valid = 1'b0;
   logic [55:0] p_data = '0;
   logic [0:0]  s_data = '0;
   logic        out_ready = 1'b0;
   logic        p_ready, s_ready, p_ov, s_ov, p_sof, s_sof, p_eof, s_eof;
   logic [15:0] p_od, s_od;
   logic        use_ser = 1'b0;
   int          vec = 0, bad = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   bpsk_null_mapper uut (
      .clk(clk), .rst(rst), .in_valid(p_valid), .in_ready(p_ready), .in_data(p_data),
      .out_valid(p_ov), .out_ready(out_ready), .out_data(p_od), .out_sof(p_sof), .out_eof(p_eof));

   bpsk_null_mapper #(.IN_MODE(IN_SERIAL)) uut_ser (
      .clk(clk), .rst(rst), .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
      .out_valid(s_ov), .out_ready(out_ready), .out_data(s_od), .out_sof(s_sof), .out_eof(s_eof));

   wire        o_valid = use_ser ? s_ov    : p_ov;
   wire [15:0] o_data  = use_ser ? s_od    : p_od;
   wire        o_sof   = use_ser ? s_sof   : p_sof;
   wire        o_eof   = use_ser ? s_eof   : p_eof;
   wire        o_irdy  = use_ser ? s_ready : p_ready;

   function automatic logic [15:0] exp_s(input logic [55:0] f, input int k);
      int b;
      if (k == 0 || (k >= 29 && k <= 35)) return 16'h0000;
      b = (k <= 28) ? k - 1 : k - 8;
      return f[b] ? 16'h3FFF : 16'hBFFD;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic push_par(input logic [55:0] f);
      @(negedge clk); p_valid = 1'b1; p_data = f;
      while (!p_ready) @(negedge clk);
      @(negedge clk); p_valid = 1'b0;
   endtask

   task automatic push_ser(input logic [55:0] f);
      for (int i = 0; i < 56; i++) begin
         @(negedge clk); s_valid = 1'b1; s_data[0] = f[i];
         while (!s_ready) @(negedge clk);
      end
      @(negedge clk); s_valid = 1'b0;
   endtask

   // called at a negedge with the frame already loaded
   task automatic drain(input logic [55:0] f, input int stall_pct, input bit poke, input string tag);
      int k = 0;
      string req;
      while (k < 64) begin
         out_ready = ($urandom_range(99) >= stall_pct);
         if (poke) begin p_valid = 1'b1; p_data = ~f; end
         req = (k == 0) ? "R3" : (k >= 29 && k <= 35) ? "R4" : "R5";
         if (tag != "") req = tag;
         chk(o_valid == 1'b1, "R6 valid", o_valid, 1);
         chk(o_data == exp_s(f, k), req, o_data, exp_s(f, k));
         if (k == 1) chk(o_data == (f[0] ? 16'h3FFF : 16'hBFFD), "R2", o_data, f[0] ? 16'h3FFF : 16'hBFFD);
         chk(o_sof == (k == 0), "R3 sof", o_sof, k == 0);
         chk(o_eof == (k == 63), "R6 eof", o_eof, k == 63);
         chk(o_irdy == 1'b0, "R7 busy", o_irdy, 0);
         @(posedge clk);
         if (out_ready) k++;
         @(negedge clk);
      end
      p_valid = 1'b0;
      out_ready = 1'b0;
      chk(o_valid == 1'b0, "R6 count", o_valid, 0);
      chk(o_irdy == 1'b1, "R7 reopen", o_irdy, 1);
   endtask

   initial begin
      logic [55:0] f;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1
      chk(p_ov == 1'b0, "R1", p_ov, 0);
      chk(p_ready == 1'b1, "R1", p_ready, 1);
      chk(s_ov == 1'b0, "R1", s_ov, 0);
      chk(s_ready == 1'b1, "R1", s_ready, 1);

      void'($urandom(32'd1234));
      // R2 directed extremes
      push_par(56'h0); drain(56'h0, 0, 1'b0, "");
      push_par({56{1'b1}}); drain({56{1'b1}}, 0, 1'b0, "");
      // R5 alternating pattern with R8 heavy stall
      push_par(56'hAA_AAAA_AAAA_AAAA); drain(56'hAA_AAAA_AAAA_AAAA, 70, 1'b0, "");
      // R7 input offered while busy must be ignored
      f = 56'h12_3456_789A_BCDE;
      push_par(f); drain(f, 30, 1'b1, "");
      // R5 R8 random frames with random back-pressure
      for (int n = 0; n < 6; n++) begin
         f = {$urandom, $urandom};
         push_par(f); drain(f, n * 12, 1'b0, "");
      end

      // R10 reset in mid-frame
      f = 56'hF0_0F0F_F0F0_0FF0;
      push_par(f);
      out_ready = 1'b1;
      repeat (10) @(negedge clk);
      rst = 1'b1; out_ready = 1'b0;
      @(negedge clk); rst = 1'b0;
      chk(p_ov == 1'b0, "R10 idle", p_ov, 0);
      chk(p_ready == 1'b1, "R10 ready", p_ready, 1);
      f = 56'h5A_C3A5_0FF0_1E2D;
      push_par(f); drain(f, 20, 1'b0, "R10");

      // R9 serial input form
      use_ser = 1'b1;
      f = 56'h80_0000_0000_0001;
      push_ser(f); drain(f, 10, 1'b0, "R9");
      f = {$urandom, $urandom};
      push_ser(f); drain(f, 40, 1'b0, "R9");
      use_ser = 1'b0;

      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

endmodule